// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether the receive pair of a 10BASE-T style link is wired backwards and, if so, undoes the reversal on the receive data path. Its inputs are digital event strobes from the line receiver: a correctly polarised normal link pulse, an inverted normal link pulse, and a fast-link-pulse clock burst together with the polarity seen in that burst. Pulse qualification, auto-negotiation arbitration and data decoding are handled elsewhere.

Two criteria declare reversal. The first is a run of `NLP_RUN` inverted normal link pulses with no correctly polarised pulse among them. The second is a single inverted fast-link-pulse burst. Detection only runs while the link is in auto-negotiation or 10BASE-T operation, which the `mode_ok` input signals. A small register interface carries two bits: an auto-polarity disable bit, and a reversed-polarity bit. While automatic mode is active the reversed-polarity bit is status. While automatic mode is disabled it becomes a software override.

Receive data passes through a valid/ready stream stage with no storage. Every bit of `in_data` is inverted while `rev_pol` is 1. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so back-pressure from the consumer reaches the producer in the same cycle. A beat is transferred on any cycle in which both `out_valid` and `out_ready` are high.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset `apol_dis` is 0, `rev_pol` is 0, and `out_data` equals `in_data`.
- R2: When `mode_ok` and `link_up` are high and `apol_dis` is 0, the `NLP_RUN`th (default 8) consecutive `nlp_inv` strobe sets `rev_pol` to 1 in the following cycle.
- R3: An `nlp_ok` strobe restarts the run count. With the default setting, 7 inverted pulses, one normal pulse and then 7 more inverted pulses leave `rev_pol` at 0.
- R4: A cycle with both `flp_burst` and `flp_burst_inv` high sets `rev_pol` to 1 in the following cycle. A burst with `flp_burst_inv` low has no effect.
- R5: `out_data` is `in_data` with every bit inverted when `rev_pol` is 1, and is unchanged otherwise. `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle.
- R6: While `mode_ok` is low, link-pulse strobes neither set `rev_pol` nor advance the run count.
- R7: Once `apol_dis` is 1, inverted pulses and bursts no longer change `rev_pol`. A register write (`cfg_wr`) made while `apol_dis` is 1 loads `cfg_wr_rev` into `rev_pol` for the next cycle, and that value forces the inversion.
- R8: A register write made while `apol_dis` is 0 updates `apol_dis` but does not load `cfg_wr_rev` into `rev_pol`.
- R9: With `apol_dis` at 0, `link_up` low clears `rev_pol` to 0 in the next cycle. With `apol_dis` at 1, `rev_pol` is kept through link loss.
- R10: `cfg_wr` loads `cfg_wr_apol_dis` into `apol_dis` for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ok | input | 1 | Link is in auto-negotiation or 10BASE-T operation |
| link_up | input | 1 | Link present |
| nlp_ok | input | 1 | Correctly polarised normal link pulse strobe |
| nlp_inv | input | 1 | Inverted normal link pulse strobe |
| flp_burst | input | 1 | Fast-link-pulse clock burst seen strobe |
| flp_burst_inv | input | 1 | The burst flagged by `flp_burst` was inverted |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wr_apol_dis | input | 1 | Write value for the auto-polarity disable bit |
| cfg_wr_rev | input | 1 | Write value for the reversed-polarity bit |
| apol_dis | output | 1 | Auto-polarity disable bit (1 = automatic mode off) |
| rev_pol | output | 1 | Reversed-polarity bit; receive data is inverted while it is 1 |
| in_valid | input | 1 | Receive data valid from the decoder |
| in_ready | output | 1 | Block can accept receive data |
| in_data | input | DATA_W | Receive data from the decoder |
| out_valid | output | 1 | Corrected data valid |
| out_ready | input | 1 | Consumer accepts corrected data |
| out_data | output | DATA_W | Polarity-corrected receive data |

## Verification
The bench builds the block with `DATA_W` = 8 and `NLP_RUN` = 8. Eight bits make a full inversion easy to tell apart from a pass-through with the patterns A5, 3C and 00. A run length of eight puts the detection threshold within reach of short pulse trains, so the 7-then-normal boundary and the exact 8th pulse can both be checked. The same settings cover the override path, the link-loss clear in each mode, and same-cycle back-pressure.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef struct packed {
    logic apol_dis;
    logic rev;
  } rxpol_cfg_t;

  localparam rxpol_cfg_t RXPOL_CFG_RESET = '{apol_dis: 1'b0, rev: 1'b0};
endpackage

// File: rtl/rxpol_nlp_run.sv
// Counts consecutive inverted normal link pulses; flags the run-completing one.
module rxpol_nlp_run #(
  parameter int NLP_RUN = 8,
  localparam int CNT_W = $clog2(NLP_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             nlp_ok,
  input  logic             nlp_inv,
  output logic             run_hit,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NLP_RUN - 1);

  logic inv_seen;
  assign inv_seen = en && nlp_inv && !nlp_ok;
  assign run_hit  = inv_seen && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!en || nlp_ok || run_hit) begin
      run_cnt <= '0;
    end else if (inv_seen) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxpol_ctrl.sv
// Holds the disable and reversed-polarity bits; arbitrates auto vs. software.
module rxpol_ctrl
  import rxpol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       detect_hit,
  input  logic       cfg_wr,
  input  logic       cfg_wr_apol_dis,
  input  logic       cfg_wr_rev,
  output rxpol_cfg_t cfg
);
  rxpol_cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg;
    if (cfg_wr) cfg_n.apol_dis = cfg_wr_apol_dis;
    if (cfg.apol_dis) begin
      if (cfg_wr) cfg_n.rev = cfg_wr_rev;
    end else if (!link_up) begin
      cfg_n.rev = 1'b0;
    end else if (detect_hit) begin
      cfg_n.rev = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= RXPOL_CFG_RESET;
    else        cfg <= cfg_n;
  end
endmodule

// File: rtl/rxpol_invert.sv
// Storage-free stream stage that flips every data bit on request.
module rxpol_invert #(
  parameter int DATA_W = 8
) (
  input  logic              flip,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign out_data[b] = in_data[b] ^ flip;
  end
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
  import rxpol_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NLP_RUN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ok,
  input  logic              link_up,
  input  logic              nlp_ok,
  input  logic              nlp_inv,
  input  logic              flp_burst,
  input  logic              flp_burst_inv,
  input  logic              cfg_wr,
  input  logic              cfg_wr_apol_dis,
  input  logic              cfg_wr_rev,
  output logic              apol_dis,
  output logic              rev_pol,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(NLP_RUN + 1);

  rxpol_cfg_t       cfg;
  logic             detect_en;
  logic             run_hit;
  logic             burst_hit;
  logic [CNT_W-1:0] nlp_cnt;

  assign detect_en = mode_ok && link_up && !cfg.apol_dis;
  assign burst_hit = detect_en && flp_burst && flp_burst_inv;

  rxpol_nlp_run #(.NLP_RUN(NLP_RUN)) run_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (detect_en),
    .nlp_ok  (nlp_ok),
    .nlp_inv (nlp_inv),
    .run_hit (run_hit),
    .run_cnt (nlp_cnt)
  );

  rxpol_ctrl ctrl_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_up         (link_up),
    .detect_hit      (run_hit || burst_hit),
    .cfg_wr          (cfg_wr),
    .cfg_wr_apol_dis (cfg_wr_apol_dis),
    .cfg_wr_rev      (cfg_wr_rev),
    .cfg             (cfg)
  );

  rxpol_invert #(.DATA_W(DATA_W)) inv_i (
    .flip      (cfg.rev),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assign apol_dis = cfg.apol_dis;
  assign rev_pol  = cfg.rev;
endmodule

// File: rtl/rxpol_checker.sv
module rxpol_checker #(
  parameter int DATA_W  = 8,
  parameter int NLP_RUN = 8,
  localparam int CNT_W = $clog2(NLP_RUN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ok,
  input logic              link_up,
  input logic              nlp_inv,
  input logic              flp_burst,
  input logic              flp_burst_inv,
  input logic              cfg_wr,
  input logic              cfg_wr_apol_dis,
  input logic              apol_dis,
  input logic              rev_pol,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  nlp_cnt
);
  assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!apol_dis && !rev_pol && !(mode_ok && link_up && (nlp_inv || (flp_burst && flp_burst_inv))))
      |=> !rev_pol);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_cnt < CNT_W'(NLP_RUN));

  assert_idle_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && !apol_dis && !rev_pol) |=> !rev_pol);

  assert_data_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_data == (rev_pol ? ~in_data : in_data));

  assert_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apol_dis && !cfg_wr) |=> $stable(rev_pol));

  assert_link_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !apol_dis) |=> !rev_pol);

  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (apol_dis == $past(cfg_wr_apol_dis)));
endmodule

bind rx_polarity_fix rxpol_checker #(.DATA_W(DATA_W), .NLP_RUN(NLP_RUN)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_ok         (mode_ok),
  .link_up         (link_up),
  .nlp_inv         (nlp_inv),
  .flp_burst       (flp_burst),
  .flp_burst_inv   (flp_burst_inv),
  .cfg_wr          (cfg_wr),
  .cfg_wr_apol_dis (cfg_wr_apol_dis),
  .apol_dis        (apol_dis),
  .rev_pol         (rev_pol),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_data         (in_data),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_data        (out_data),
  .nlp_cnt         (nlp_cnt)
);

// File: tb/rx_polarity_fix_tb_top.sv
module rx_polarity_fix_tb_top;
  localparam int DATA_W  = 8;
  localparam int NLP_RUN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ok = 1'b1, link_up = 1'b1;
  logic nlp_ok = 1'b0, nlp_inv = 1'b0, flp_burst = 1'b0, flp_burst_inv = 1'b0;
  logic cfg_wr = 1'b0, cfg_wr_apol_dis = 1'b0, cfg_wr_rev = 1'b0;
  logic apol_dis, rev_pol;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0, out_data;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  rx_polarity_fix #(.DATA_W(DATA_W), .NLP_RUN(NLP_RUN)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulses_inv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) nlp_inv = 1'b1;
      @(negedge clk) nlp_inv = 1'b0;
    end
  endtask

  task automatic pulse_ok();
    @(negedge clk) nlp_ok = 1'b1;
    @(negedge clk) nlp_ok = 1'b0;
  endtask

  task automatic burst(logic inv);
    @(negedge clk) begin flp_burst = 1'b1; flp_burst_inv = inv; end
    @(negedge clk) begin flp_burst = 1'b0; flp_burst_inv = 1'b0; end
  endtask

  task automatic wr(logic dis, logic rv);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_wr_apol_dis = dis; cfg_wr_rev = rv; end
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic drop_link();
    @(negedge clk) link_up = 1'b0;
    @(negedge clk) link_up = 1'b1;
  endtask

  task automatic t_reset();
    in_data = 8'hA5;
    #1;
    chk("R1 apol_dis", 32'(apol_dis), 0);
    chk("R1 rev_pol", 32'(rev_pol), 0);
    chk("R1 data", 32'(out_data), 32'hA5);
  endtask

  task automatic t_nlp_run();
    pulses_inv(7);
    pulse_ok();
    pulses_inv(7);
    chk("R3 seven after normal", 32'(rev_pol), 0);
    pulses_inv(1);
    chk("R2 eighth consecutive", 32'(rev_pol), 1);
    in_data = 8'h3C; in_valid = 1'b1; out_ready = 1'b0; #1;
    chk("R5 inverted data", 32'(out_data), 32'hC3);
    chk("R5 valid", 32'(out_valid), 1);
    chk("R5 ready low", 32'(in_ready), 0);
    out_ready = 1'b1; #1;
    chk("R5 ready high", 32'(in_ready), 1);
    in_valid = 1'b0;
  endtask

  task automatic t_link_loss_auto();
    drop_link();
    chk("R9 auto clear", 32'(rev_pol), 0);
    #1 chk("R5 passthrough", 32'(out_data), 32'h3C);
  endtask

  task automatic t_burst();
    burst(1'b0);
    chk("R4 normal burst", 32'(rev_pol), 0);
    burst(1'b1);
    chk("R4 inverted burst", 32'(rev_pol), 1);
    drop_link();
  endtask

  task automatic t_mode_off();
    @(negedge clk) mode_ok = 1'b0;
    pulses_inv(8);
    chk("R6 mode off", 32'(rev_pol), 0);
    @(negedge clk) mode_ok = 1'b1;
    pulses_inv(1);
    chk("R6 count not advanced", 32'(rev_pol), 0);
    pulse_ok();
  endtask

  task automatic t_auto_write();
    wr(1'b0, 1'b1);
    chk("R8 auto write ignored", 32'(rev_pol), 0);
    chk("R10 apol stays 0", 32'(apol_dis), 0);
  endtask

  task automatic t_manual();
    wr(1'b1, 1'b0);
    chk("R10 apol set", 32'(apol_dis), 1);
    pulses_inv(8);
    burst(1'b1);
    chk("R7 detection off", 32'(rev_pol), 0);
    wr(1'b1, 1'b1);
    chk("R7 forced", 32'(rev_pol), 1);
    in_data = 8'h00; #1;
    chk("R7 forced inversion", 32'(out_data), 32'hFF);
    drop_link();
    chk("R9 manual kept", 32'(rev_pol), 1);
    wr(1'b0, 1'b0);
    chk("R10 apol cleared", 32'(apol_dis), 0);
    chk("R7 manual write on exit", 32'(rev_pol), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nlp_run();
    t_link_loss_auto();
    t_burst();
    t_mode_off();
    t_auto_write();
    t_manual();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule